// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block watches a single asynchronous interrupt pin and turns qualifying activity on it into a latched interrupt request. The pin is first brought into the clock domain through a flop synchronizer. Each cycle, the synchronized sample is compared with the sample from the cycle before to find rising and falling edges. A two-bit sensitivity setting chooses one of four behaviours. Two of them react to a single edge direction. The other two react to that edge and also keep firing for as long as the pin stays at the matching level.

Software reaches the block through one register on a plain write-enable and read-data port, with no address:

| Bit | Name | Access | Meaning |
|-----|------|--------|---------|
| 0 | edge select | read/write | 0 = falling, 1 = rising |
| 1 | level select | read/write | 1 = the matching level also triggers |
| 2 | clear | write-only | writing 1 drops the pending request; reads as 0 |
| 3 | pin status | read-only | the synchronized pin value |
| 7:4 | — | — | ignored on write, read as 0 |

The interrupt request output is the latched flag itself, driven straight from a flop. The block goes no further: priority, masking and vectoring are handled outside it.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset the irq output is 0 and rd_data reads 0x00, so the sensitivity is {level select, edge select} = 00.
- R2: With sensitivity 00, only a falling edge sets the flag. A rising edge is ignored, and a pin held low does not set the flag again once it has been cleared.
- R3: With sensitivity 01, only a rising edge sets the flag. A falling edge is ignored.
- R4: With sensitivity 10, a falling edge sets the flag. While the pin stays low, a clear does not lower irq.
- R5: With sensitivity 11, a rising edge sets the flag. While the pin stays high, the flag is set (also straight after this mode is written) and a clear does not lower irq.
- R6: A write with bit 2 = 1 lowers irq on the next clock edge when no event occurs in that cycle. A write with bit 2 = 0 leaves the flag unchanged. Bits 1:0 are loaded only by a write.
- R7: rd_data bit 2 and bits 7:4 always read 0, whatever was written to them.
- R8: rd_data bit 3 shows the pin value from the second rising clock edge after the pin changes.
- R9: When an event and a clear fall in the same cycle, the flag stays set.
- R10: After a qualifying pin transition, irq rises on the third rising clock edge, counting the first edge after the change. It stays high until it is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_async | input | 1 | Asynchronous external interrupt pin |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Register write data |
| rd_data | output | DATA_W | Register read view |
| irq | output | 1 | Latched interrupt request |

## Verification
A wrong synchronizer or previous-sample state shows up in two places. The pin-status bit changes a cycle early or late, and irq either misses an edge or fires on a steady pin, in both cases within three clock edges of the pin change. A wrong sensitivity decode makes irq react to the wrong edge direction, or makes it fail to hold high under a clear while the pin sits at the active level, which shows on the cycle after the clear. A wrong flag priority shows on the very edge where a clear and an event meet, because irq drops when it should stay high.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned BIT_EDGE  = 0;
  localparam int unsigned BIT_LEVEL = 1;
  localparam int unsigned BIT_CLEAR = 2;
  localparam int unsigned BIT_PIN   = 3;

  typedef enum logic [1:0] {
    SENS_FALL      = 2'b00,
    SENS_RISE      = 2'b01,
    SENS_FALL_LOW  = 2'b10,
    SENS_RISE_HIGH = 2'b11
  } sens_e;
endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

  // R8: the output is the stage before it, delayed by one clock
  a_r8_sync_shift: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (chain[STAGES-1] == $past(chain[STAGES-2])));
endmodule

// File: rtl/eid_event.sv
module eid_event
  import ext_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pin_s,
  input  sens_e sens,
  output logic  hit
);
  logic prev_q;
  logic rise, fall, edge_hit, level_hit;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= pin_s;
  end

  always_comb begin
    rise      = pin_s & ~prev_q;
    fall      = ~pin_s & prev_q;
    edge_hit  = sens[BIT_EDGE] ? rise : fall;
    level_hit = sens[BIT_LEVEL] && (pin_s == sens[BIT_EDGE]);
    hit       = edge_hit | level_hit;
  end

  // R2: in an edge-only mode, a steady pin never produces an event
  a_r2_steady_no_hit: assert property (@(posedge clk) disable iff (rst)
    (!sens[BIT_LEVEL] && pin_s == $past(pin_s)) |-> !hit);
  // R4: a low pin in falling-plus-low mode is always an event
  a_r4_low_level: assert property (@(posedge clk) disable iff (rst)
    (sens == SENS_FALL_LOW && !pin_s) |-> hit);
  // R5: a high pin in rising-plus-high mode is always an event
  a_r5_high_level: assert property (@(posedge clk) disable iff (rst)
    (sens == SENS_RISE_HIGH && pin_s) |-> hit);
endmodule

// File: rtl/eid_flag.sv
module eid_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R9: an event beats a clear in the same cycle
  a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);
  // R6: a clear with no event drops the flag
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !flag);
  // R10: with no event and no clear the flag holds
  a_r10_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (!clr && !hit) |=> $stable(flag));
endmodule

// File: rtl/eid_ctrl.sv
module eid_ctrl
  import ext_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pin_s,
  output sens_e             sens,
  output logic              clr,
  output logic [DATA_W-1:0] rd_data
);
  logic unused_hi;

  always_ff @(posedge clk) begin
    if (rst)        sens <= SENS_FALL;
    else if (wr_en) sens <= sens_e'({wr_data[BIT_LEVEL], wr_data[BIT_EDGE]});
  end

  assign clr       = wr_en & wr_data[BIT_CLEAR];
  assign unused_hi = ^wr_data[DATA_W-1:BIT_PIN];

  always_comb begin
    rd_data            = '0;
    rd_data[BIT_EDGE]  = sens[0];
    rd_data[BIT_LEVEL] = sens[1];
    rd_data[BIT_PIN]   = pin_s;
  end

  // R6: the sensitivity changes only by a write
  a_r6_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(sens));
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_async,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int MIN_W = BIT_PIN + 1;

  logic  pin_s;
  logic  hit;
  logic  clr;
  sens_e sens;

  initial begin
    if (DATA_W < MIN_W || SYNC_STAGES < 2)
      $error("ext_irq_detect: bad parameters");
  end

  eid_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_async), .dout(pin_s));

  eid_event u_event (
    .clk(clk), .rst(rst), .pin_s(pin_s), .sens(sens), .hit(hit));

  eid_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pin_s(pin_s), .sens(sens), .clr(clr), .rd_data(rd_data));

  eid_flag u_flag (
    .clk(clk), .rst(rst), .hit(hit), .clr(clr), .flag(irq));

  // R7: bit 2 and bits 7:4 of the read view are never set
  a_r7_zero_bits: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (rd_data[BIT_CLEAR] == 1'b0 && rd_data[DATA_W-1:MIN_W] == '0));
endmodule

// File: tb/test_ext_irq_detect.sv
module test_ext_irq_detect;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_async = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;

  ext_irq_detect i_ext_irq_detect (
    .clk(clk), .rst(rst), .pin_async(pin_async), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always #4 clk = ~clk;

  typedef struct {
    string      tag;
    logic       irq;
    logic [7:0] rd;
  } exp_t;

  exp_t sb[$];
  int   errors = 0;
  int   checks = 0;
  logic m_edge = 1'b0;
  logic m_lvl  = 1'b0;
  bit   done   = 1'b0;

  // Each item is compared 2 ns after the next rising edge.
  task automatic chk(input string tag, input logic e_irq, input logic e_pin);
    exp_t it;
    it.tag = tag;
    it.irq = e_irq;
    it.rd  = {4'b0000, e_pin, 1'b0, m_lvl, m_edge};
    sb.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setpin(input logic v);
    tick();
    pin_async = v;
  endtask

  task automatic write(input logic [7:0] d);
    tick();
    wr_en   = 1'b1;
    wr_data = d;
    m_edge  = d[0];
    m_lvl   = d[1];
  endtask

  // Monitor: compares every expected item against the ports.
  always @(posedge clk) begin
    #2;
    while (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (irq !== it.irq || rd_data !== it.rd) begin
        errors++;
        $display("FAIL %s: irq=%b rd=%h, expected irq=%b rd=%h",
                 it.tag, irq, rd_data, it.irq, it.rd);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1", 1'b0, 1'b0);

    // R2 / R8 / R10: falling-only mode
    setpin(1'b1); chk("R2", 1'b0, 1'b0);
    tick();       chk("R8", 1'b0, 1'b1);
    tick();       chk("R2", 1'b0, 1'b1);
    setpin(1'b0); chk("R10", 1'b0, 1'b1);
    tick();       chk("R10", 1'b0, 1'b0);
    tick();       chk("R2", 1'b1, 1'b0);
    tick();       chk("R10", 1'b1, 1'b0);
    write(8'h04); chk("R6", 1'b0, 1'b0);
    tick();       chk("R2", 1'b0, 1'b0);
    setpin(1'b1); tick(); tick();
    setpin(1'b0); tick();
    tick();       chk("R2", 1'b1, 1'b0);
    write(8'h00); chk("R6", 1'b1, 1'b0);
    tick();       chk("R6", 1'b1, 1'b0);
    write(8'h05); chk("R6", 1'b0, 1'b0);

    // R3: rising-only mode
    setpin(1'b1); chk("R3", 1'b0, 1'b0);
    tick();       chk("R8", 1'b0, 1'b1);
    tick();       chk("R3", 1'b1, 1'b1);
    write(8'h05); chk("R6", 1'b0, 1'b1);
    setpin(1'b0); tick();
    tick();       chk("R3", 1'b0, 1'b0);
    tick();       chk("R3", 1'b0, 1'b0);
    setpin(1'b1); tick();
    tick();       chk("R3", 1'b1, 1'b1);
    setpin(1'b0); tick(); tick();
    tick();       chk("R3", 1'b1, 1'b0);

    // R9: clear meets a rising edge in the same cycle
    setpin(1'b1); tick();
    write(8'h05); chk("R9", 1'b1, 1'b1);
    tick();       chk("R9", 1'b1, 1'b1);
    write(8'h05); chk("R6", 1'b0, 1'b1);

    // R4: falling plus low level
    write(8'h02); chk("R4", 1'b0, 1'b1);
    setpin(1'b0); tick();
    tick();       chk("R4", 1'b1, 1'b0);
    write(8'h06); chk("R4", 1'b1, 1'b0);
    tick();       chk("R4", 1'b1, 1'b0);
    setpin(1'b1); tick();
    tick();       chk("R4", 1'b1, 1'b1);
    write(8'h06); chk("R4", 1'b0, 1'b1);
    tick();       chk("R4", 1'b0, 1'b1);

    // R5: rising plus high level
    write(8'h03); chk("R5", 1'b0, 1'b1);
    tick();       chk("R5", 1'b1, 1'b1);
    write(8'h07); chk("R5", 1'b1, 1'b1);
    setpin(1'b0); tick();
    tick();       chk("R5", 1'b1, 1'b0);
    write(8'h07); chk("R5", 1'b0, 1'b0);
    tick();       chk("R5", 1'b0, 1'b0);
    setpin(1'b1); tick();
    tick();       chk("R5", 1'b1, 1'b1);

    // R7: upper bits and the clear bit read 0
    write(8'hF3); chk("R7", 1'b1, 1'b1);
    tick();       chk("R7", 1'b1, 1'b1);

    tick(); tick(); tick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule